// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block turns a bit clock into a periodic frame-sync pulse for a serial audio port. Each frame lasts a programmable number of bit clocks and its pulse stays active for a programmable number of bit clocks. Both counts are written as the value minus one. The bit clock is either a divided version of the system clock or the rising edges of an external clock input, brought into the system clock domain first. Either way, frame sync is still produced inside the block.

The clock generator and frame-sync generation have separate enables. Each direction (index 0 for transmit, 1 for receive) has its own master/slave selection for its clock pin and its frame-sync pin. A master frame-sync pin carries the generated pulse with a selectable polarity. A slave direction leaves its pin undriven and passes the external frame sync inward, normalised to active high, on its internal frame output. New period and width values are taken up only at a frame boundary, so a running stream never sees a torn frame.

Top module: `fsg_top`

## Requirements
- R1: Out of reset, and while the generator is disabled, `frame_o` and `frame_start_o` are 0 and a master frame-sync pin rests at its inactive level, which equals `cfg_fs_pol`.
- R2: With both enables set, frames repeat every `cfg_period_m1`+1 bit ticks.
- R3: The frame-sync pulse begins at the start of each frame and lasts `cfg_width_m1`+1 bit ticks, for any width field below the period field.
- R4: With the internal source selected, one bit tick occurs every `cfg_div_m1`+1 system clocks while `cfg_gen_en` is 1.
- R5: With `cfg_clk_ext`=1, one bit tick occurs for each rising edge of `ext_bclk_i`, after a two-stage synchroniser, and frame sync is still generated internally.
- R6: The first pulse starts on the first bit tick after both enables are high. With `cfg_div_m1`=0 this is the next clock edge.
- R7: A write to the period or width field takes effect at the next frame start. The frame already in progress keeps its old length.
- R8: Clearing `cfg_gen_en` drops the frame sync at the next clock edge and resets the counter. Re-enabling starts a fresh full frame.
- R9: While `cfg_fs_en` is 0, no pulse and no frame-start strobe are produced, even with the generator running.
- R10: With `cfg_fs_pol`=1 the pins use active-low frame sync. A master pin drives `frame_o` XOR `cfg_fs_pol`, and a slave direction presents `fs_pin_i` XOR `cfg_fs_pol` on `frame_o`.
- R11: For each direction, pin output enables follow that direction's master bits, and a pin that is not enabled is driven 0. A master clock pin carries the generated bit clock, which toggles every system clock when `cfg_div_m1`=1.
- R12: `frame_start_o` is a one-cycle strobe in the cycle in which each frame begins, coinciding with the rising edge of the generated frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_bclk_i | input | 1 | External bit clock input |
| cfg_gen_en | input | 1 | Clock generator enable |
| cfg_fs_en | input | 1 | Frame-sync generation enable |
| cfg_clk_ext | input | 1 | 1: bit tick from external clock, 0: internal divider |
| cfg_div_m1 | input | DIV_W | Internal divide ratio minus one |
| cfg_period_m1 | input | CNT_W | Frame period in bit ticks minus one |
| cfg_width_m1 | input | CNT_W | Pulse width in bit ticks minus one |
| cfg_fs_pol | input | 1 | 1: frame sync active low on the pins |
| cfg_fs_master | input | 2 | Per direction: drive frame-sync pin (1) or sample it (0) |
| cfg_clk_master | input | 2 | Per direction: drive bit-clock pin |
| fs_pin_i | input | 2 | Frame-sync pin input levels |
| fs_pin_o | output | 2 | Frame-sync pin output levels |
| fs_pin_oe | output | 2 | Frame-sync pin output enables |
| bclk_pin_o | output | 2 | Bit-clock pin output levels |
| bclk_pin_oe | output | 2 | Bit-clock pin output enables |
| frame_o | output | 2 | Active-high frame sync seen by each direction |
| frame_start_o | output | 1 | Strobe at each generated frame start |

## Verification
The hardest case to reach from the ports is a period change that lands in the middle of a running frame. The stimulus has to align exactly to a generated rising edge before it writes the new values. Only then can the length of the current frame be told apart from the length of the one after it. The bench synchronises on the sampled rising edge of `frame_o` and writes the fields in that same cycle. It then counts clocks to the next two rising edges, expecting the old period and then the new one. The generator-stop case is reached the same way: the enable is cleared in the first cycle of an active pulse, so the truncation is visible at once.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int FSG_NDIR = 2;

  typedef enum logic [0:0] {
    FSG_DIR_TX = 1'b0,
    FSG_DIR_RX = 1'b1
  } fsg_dir_e;
endpackage

// File: rtl/fsg_bit_tick.sv
module fsg_bit_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             clk_ext,
  input  logic [DIV_W-1:0] div_m1,
  input  logic             ext_bclk_i,
  output logic             bit_tick,
  output logic             bclk_lvl
);
  localparam int SYNC_STAGES = 2;

  // High during the first half of each divided period.
  function automatic logic half_high(input logic [DIV_W-1:0] cnt,
                                     input logic [DIV_W-1:0] div);
    logic [DIV_W:0] half;
    half = ({1'b0, div} + 1'b1) >> 1;
    return ({1'b0, cnt} < half);
  endfunction

  logic [DIV_W-1:0]       div_cnt;
  logic [SYNC_STAGES:0]   ext_sync;
  logic                   int_wrap;
  logic                   ext_rise;

  assign int_wrap = (div_cnt >= div_m1);
  assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_sync[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!gen_en || clk_ext) begin
      div_cnt <= '0;
    end else if (int_wrap) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
    end else begin
      ext_sync <= {ext_sync[SYNC_STAGES-1:0], ext_bclk_i};
    end
  end

  always_comb begin
    if (!gen_en) begin
      bit_tick = 1'b0;
      bclk_lvl = 1'b0;
    end else if (clk_ext) begin
      bit_tick = ext_rise;
      bclk_lvl = ext_sync[SYNC_STAGES-1];
    end else begin
      bit_tick = int_wrap;
      bclk_lvl = half_high(div_cnt, div_m1);
    end
  end
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             fs_en,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] period_m1,
  input  logic [CNT_W-1:0] width_m1,
  output logic             fs_active,
  output logic             frame_start,
  output logic             running,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] per_q
);
  logic [CNT_W-1:0] wid_q;
  logic             frame_begin;
  logic             armed;
  logic [CNT_W-1:0] cnt_next;

  function automatic logic in_pulse(input logic [CNT_W-1:0] idx,
                                    input logic [CNT_W-1:0] wid);
    return (idx <= wid);
  endfunction

  assign armed       = gen_en & fs_en;
  assign frame_begin = armed & bit_tick & (!running || (bit_cnt == per_q));
  assign cnt_next    = bit_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      fs_active   <= 1'b0;
      frame_start <= 1'b0;
      bit_cnt     <= '0;
      per_q       <= '0;
      wid_q       <= '0;
    end else if (!armed) begin
      running     <= 1'b0;
      fs_active   <= 1'b0;
      frame_start <= 1'b0;
      bit_cnt     <= '0;
    end else if (frame_begin) begin
      running     <= 1'b1;
      fs_active   <= 1'b1;
      frame_start <= 1'b1;
      bit_cnt     <= '0;
      per_q       <= period_m1;
      wid_q       <= width_m1;
    end else if (bit_tick) begin
      bit_cnt     <= cnt_next;
      fs_active   <= in_pulse(cnt_next, wid_q);
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
    end
  end
endmodule

// File: rtl/fsg_pin_mux.sv
module fsg_pin_mux (
  input  logic fs_active,
  input  logic bclk_lvl,
  input  logic pol,
  input  logic fs_master,
  input  logic clk_master,
  input  logic fs_pin_i,
  output logic fs_pin_o,
  output logic fs_pin_oe,
  output logic bclk_pin_o,
  output logic bclk_pin_oe,
  output logic frame_o
);
  always_comb begin
    fs_pin_oe   = fs_master;
    bclk_pin_oe = clk_master;
    bclk_pin_o  = clk_master & bclk_lvl;
    if (fs_master) begin
      fs_pin_o = fs_active ^ pol;
      frame_o  = fs_active;
    end else begin
      fs_pin_o = 1'b0;
      frame_o  = fs_pin_i ^ pol;
    end
  end
endmodule

// File: rtl/fsg_top.sv
module fsg_top
  import fsg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_bclk_i,
  input  logic                cfg_gen_en,
  input  logic                cfg_fs_en,
  input  logic                cfg_clk_ext,
  input  logic [DIV_W-1:0]    cfg_div_m1,
  input  logic [CNT_W-1:0]    cfg_period_m1,
  input  logic [CNT_W-1:0]    cfg_width_m1,
  input  logic                cfg_fs_pol,
  input  logic [FSG_NDIR-1:0] cfg_fs_master,
  input  logic [FSG_NDIR-1:0] cfg_clk_master,
  input  logic [FSG_NDIR-1:0] fs_pin_i,
  output logic [FSG_NDIR-1:0] fs_pin_o,
  output logic [FSG_NDIR-1:0] fs_pin_oe,
  output logic [FSG_NDIR-1:0] bclk_pin_o,
  output logic [FSG_NDIR-1:0] bclk_pin_oe,
  output logic [FSG_NDIR-1:0] frame_o,
  output logic                frame_start_o
);
  logic             bit_tick;
  logic             bclk_lvl;
  logic             fs_active;
  logic             frame_start;
  logic             running;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] per_q;

  fsg_bit_tick #(.DIV_W(DIV_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (cfg_gen_en),
    .clk_ext    (cfg_clk_ext),
    .div_m1     (cfg_div_m1),
    .ext_bclk_i (ext_bclk_i),
    .bit_tick   (bit_tick),
    .bclk_lvl   (bclk_lvl)
  );

  fsg_frame_ctr #(.CNT_W(CNT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_en      (cfg_gen_en),
    .fs_en       (cfg_fs_en),
    .bit_tick    (bit_tick),
    .period_m1   (cfg_period_m1),
    .width_m1    (cfg_width_m1),
    .fs_active   (fs_active),
    .frame_start (frame_start),
    .running     (running),
    .bit_cnt     (bit_cnt),
    .per_q       (per_q)
  );

  for (genvar d = 0; d < FSG_NDIR; d++) begin : g_dir
    fsg_pin_mux u_mux (
      .fs_active   (fs_active),
      .bclk_lvl    (bclk_lvl),
      .pol         (cfg_fs_pol),
      .fs_master   (cfg_fs_master[d]),
      .clk_master  (cfg_clk_master[d]),
      .fs_pin_i    (fs_pin_i[d]),
      .fs_pin_o    (fs_pin_o[d]),
      .fs_pin_oe   (fs_pin_oe[d]),
      .bclk_pin_o  (bclk_pin_o[d]),
      .bclk_pin_oe (bclk_pin_oe[d]),
      .frame_o     (frame_o[d])
    );
  end

  assign frame_start_o = frame_start;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             fs_en,
  input logic             bit_tick,
  input logic             fs_active,
  input logic             frame_start,
  input logic             running,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [CNT_W-1:0] per_q
);
  // R8: generator disable cuts the pulse at the next edge
  a_r8_gen_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !fs_active);

  // R9: frame-sync disable keeps the generator quiet
  a_r9_fs_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_en |=> (!fs_active && !frame_start));

  // R12: strobe only while the pulse is active
  a_r12_start_with_fs: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> fs_active);

  // R12: every rising pulse comes from a frame start
  a_r12_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_active) |-> frame_start);

  // R2: position in frame never exceeds the latched period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (bit_cnt <= per_q));

  // R4: without a bit tick the pulse level holds
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && fs_en && !bit_tick) |=> $stable(fs_active));
endmodule

bind fsg_top fsg_checker #(.CNT_W(CNT_W)) u_fsg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_en      (cfg_gen_en),
  .fs_en       (cfg_fs_en),
  .bit_tick    (bit_tick),
  .fs_active   (fs_active),
  .frame_start (frame_start),
  .running     (running),
  .bit_cnt     (bit_cnt),
  .per_q       (per_q)
);

// File: tb/test_fsg_top.sv
`timescale 1ns/1ps
module test_fsg_top;
  localparam int DIV_W = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_bclk_i = 1'b0;
  logic cfg_gen_en = 1'b0, cfg_fs_en = 1'b0, cfg_clk_ext = 1'b0, cfg_fs_pol = 1'b0;
  logic [DIV_W-1:0] cfg_div_m1 = '0;
  logic [CNT_W-1:0] cfg_period_m1 = '0, cfg_width_m1 = '0;
  logic [1:0] cfg_fs_master = '0, cfg_clk_master = '0, fs_pin_i = '0;
  logic [1:0] fs_pin_o, fs_pin_oe, bclk_pin_o, bclk_pin_oe, frame_o;
  logic frame_start_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit ext_run = 0;

  always #2.5 clk = ~clk;

  fsg_top #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_fsg_top (
    .clk(clk), .rst_n(rst_n), .ext_bclk_i(ext_bclk_i),
    .cfg_gen_en(cfg_gen_en), .cfg_fs_en(cfg_fs_en), .cfg_clk_ext(cfg_clk_ext),
    .cfg_div_m1(cfg_div_m1), .cfg_period_m1(cfg_period_m1), .cfg_width_m1(cfg_width_m1),
    .cfg_fs_pol(cfg_fs_pol), .cfg_fs_master(cfg_fs_master), .cfg_clk_master(cfg_clk_master),
    .fs_pin_i(fs_pin_i), .fs_pin_o(fs_pin_o), .fs_pin_oe(fs_pin_oe),
    .bclk_pin_o(bclk_pin_o), .bclk_pin_oe(bclk_pin_oe), .frame_o(frame_o),
    .frame_start_o(frame_start_o)
  );

  // external clock: toggles every two system clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph++;
        if (ph >= 2) begin ph = 0; ext_bclk_i = ~ext_bclk_i; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel 0/1: frame_o[sel]; sel 2/3: inverted fs_pin_o[sel-2]
  function automatic bit smp(input int sel);
    if (sel < 2) return frame_o[sel];
    return !fs_pin_o[sel-2];
  endfunction

  task automatic rise_wait(input int sel, output int n);
    bit prev;
    n = 0;
    prev = smp(sel);
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (!prev && smp(sel)) break;
      prev = smp(sel);
    end
  endtask

  task automatic count_frame(input int sel, output int hi, output int per);
    hi = 0; per = 0;
    while (smp(sel) && per < 4000) begin hi++; per++; @(negedge clk); end
    while (!smp(sel) && per < 4000) begin per++; @(negedge clk); end
  endtask

  task automatic meas(input int sel, output int hi, output int per);
    int n;
    rise_wait(sel, n);
    count_frame(sel, hi, per);
  endtask

  task automatic setup(input bit gen, input bit fs, input bit ext, input int d,
                       input int p, input int w, input bit pol,
                       input logic [1:0] fsm, input logic [1:0] clkm);
    @(negedge clk);
    cfg_gen_en = gen; cfg_fs_en = fs; cfg_clk_ext = ext;
    cfg_div_m1 = DIV_W'(d); cfg_period_m1 = CNT_W'(p); cfg_width_m1 = CNT_W'(w);
    cfg_fs_pol = pol; cfg_fs_master = fsm; cfg_clk_master = clkm;
  endtask

  task automatic t_reset;
    chk(frame_o == 2'b00, "R1 frame_o after reset", frame_o, 0);
    chk(frame_start_o == 1'b0, "R1 strobe after reset", frame_start_o, 0);
    setup(0, 1, 0, 0, 7, 3, 1, 2'b01, 2'b00);
    repeat (3) @(negedge clk);
    chk(fs_pin_o[0] == 1'b1, "R1 idle pin level with pol=1", fs_pin_o[0], 1);
    chk(frame_o[0] == 1'b0, "R1 no frame with generator off", frame_o[0], 0);
  endtask

  task automatic t_shape(input int p, input int w, input int d);
    int hi, per;
    setup(1, 1, 0, d, p, w, 0, 2'b11, 2'b00);
    meas(0, hi, per);
    chk(per == (p + 1) * (d + 1), "R2 R4 frame period", per, (p + 1) * (d + 1));
    chk(hi == (w + 1) * (d + 1), "R3 pulse width", hi, (w + 1) * (d + 1));
    setup(0, 0, 0, 0, 0, 0, 0, 2'b11, 2'b00);
  endtask

  task automatic t_first;
    int n;
    setup(1, 0, 0, 0, 7, 3, 0, 2'b01, 2'b00);
    repeat (4) @(negedge clk);
    cfg_fs_en = 1'b1;
    @(negedge clk);
    chk(frame_o[0] == 1'b1, "R6 first pulse at next edge", frame_o[0], 1);
    chk(frame_start_o == 1'b1, "R12 strobe with first pulse", frame_start_o, 1);
    @(negedge clk);
    chk(frame_start_o == 1'b0, "R12 strobe lasts one cycle", frame_start_o, 0);
    setup(1, 0, 0, 3, 7, 3, 0, 2'b01, 2'b00);
    repeat (5) @(negedge clk);
    cfg_fs_en = 1'b1;
    n = 0;
    while (!frame_o[0] && n < 50) begin @(negedge clk); n++; end
    chk(n >= 1 && n <= 4, "R6 first pulse within one bit tick", n, 4);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00);
  endtask

  task automatic t_update;
    int n, hi, per;
    setup(1, 1, 0, 0, 9, 2, 0, 2'b01, 2'b00);
    rise_wait(0, n);
    cfg_period_m1 = CNT_W'(5);
    cfg_width_m1 = CNT_W'(0);
    rise_wait(0, n);
    chk(n == 10, "R7 current frame keeps old period", n, 10);
    count_frame(0, hi, per);
    chk(per == 6, "R7 new period at next frame", per, 6);
    chk(hi == 1, "R7 new width at next frame", hi, 1);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00);
  endtask

  task automatic t_stop;
    int n, hi;
    setup(1, 1, 0, 0, 7, 3, 0, 2'b01, 2'b00);
    rise_wait(0, n);
    cfg_gen_en = 1'b0;
    @(negedge clk);
    chk(frame_o[0] == 1'b0, "R8 pulse cut at next edge", frame_o[0], 0);
    repeat (3) @(negedge clk);
    cfg_gen_en = 1'b1;
    @(negedge clk);
    chk(frame_o[0] == 1'b1 && frame_start_o == 1'b1, "R8 fresh frame on restart",
        {frame_o[0], frame_start_o}, 3);
    hi = 0;
    while (frame_o[0] && hi < 50) begin hi++; @(negedge clk); end
    chk(hi == 4, "R8 full pulse after restart", hi, 4);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00);
  endtask

  task automatic t_quiet;
    int seen = 0;
    setup(1, 0, 0, 0, 3, 1, 0, 2'b11, 2'b00);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (frame_o != 2'b00 || frame_start_o) seen++;
    end
    chk(seen == 0, "R9 no pulse with frame sync disabled", seen, 0);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
  endtask

  task automatic t_pol;
    int hi, per;
    setup(1, 1, 0, 1, 5, 1, 1, 2'b01, 2'b00);
    meas(2, hi, per);
    chk(hi == 4, "R10 active-low pin width", hi, 4);
    chk(per == 12, "R10 active-low pin period", per, 12);
    chk(fs_pin_o[0] == !frame_o[0], "R10 pin is inverted frame", fs_pin_o[0], !frame_o[0]);
    chk(fs_pin_oe == 2'b01, "R11 fs oe follows master bits", fs_pin_oe, 1);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
  endtask

  task automatic t_slave;
    setup(1, 1, 0, 0, 7, 3, 0, 2'b01, 2'b00);
    fs_pin_i = 2'b10;
    @(negedge clk);
    chk(fs_pin_oe[1] == 1'b0 && fs_pin_o[1] == 1'b0, "R11 slave pin undriven",
        {fs_pin_oe[1], fs_pin_o[1]}, 0);
    chk(frame_o[1] == 1'b1, "R10 slave passes pin (pol=0)", frame_o[1], 1);
    cfg_fs_pol = 1'b1;
    @(negedge clk);
    chk(frame_o[1] == 1'b0, "R10 slave inverts pin (pol=1, high)", frame_o[1], 0);
    fs_pin_i = 2'b00;
    @(negedge clk);
    chk(frame_o[1] == 1'b1, "R10 slave inverts pin (pol=1, low)", frame_o[1], 1);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
  endtask

  task automatic t_bclk;
    bit a, b;
    setup(1, 0, 0, 1, 7, 3, 0, 2'b00, 2'b01);
    repeat (2) @(negedge clk);
    a = bclk_pin_o[0];
    @(negedge clk);
    b = bclk_pin_o[0];
    chk(a != b, "R11 master clock pin toggles", b, !a);
    chk(bclk_pin_oe == 2'b01, "R11 clock oe follows master bits", bclk_pin_oe, 1);
    chk(bclk_pin_o[1] == 1'b0, "R11 slave clock pin driven 0", bclk_pin_o[1], 0);
    setup(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
  endtask

  task automatic t_ext;
    int hi, per;
    ext_run = 1;
    setup(1, 1, 1, 0, 3, 1, 0, 2'b11, 2'b00);
    meas(1, hi, per);
    chk(per == 16, "R5 period from external clock", per, 16);
    chk(hi == 8, "R5 width from external clock", hi, 8);
    ext_run = 0;
    setup(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shape(31, 15, 0);
    t_shape(7, 0, 1);
    t_shape(4, 2, 2);
    t_first();
    t_update();
    t_stop();
    t_quiet();
    t_pol();
    t_slave();
    t_bclk();
    t_ext();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule